// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between an 8-bit controller core and its byte-wide data RAM. Each request names an address mode, and the block turns it into a 12-bit data address. The mode is one of three: the bank register joined with an 8-bit offset, a fixed access window that never looks at the bank register, or a complete 12-bit address for memory-to-memory moves. The block then reads from or writes to the RAM, which it holds internally. A move is issued as two full-address requests: a read, then a write.

The address space is 16 banks of 256 bytes each. A parameter mask marks which banks exist, and the top bank (the special function area) always exists. Storage is allocated only for banks that exist. A write to a missing bank is dropped, and a read from a missing bank returns zero. Every request still produces a completion strobe, so the core carries on as if the access had succeeded. Read data arrives one cycle after the request, together with that strobe.

Top module: `bmau_top`

## Requirements
- R1: In banked mode (req_mode 0) the address is the bank register as bits 11:8 joined with req_offset as bits 7:0.
- R2: After reset the bank register is 0. bank_value shows the register in bits 3:0, and its bits 7:4 always read 0 whatever value is loaded.
- R3: When bank_load is high, bank_load_val[3:0] appears on bank_value after the next edge. A request in the same cycle as the load uses the old bank value.
- R4: In access mode (req_mode 1), an offset below 0x60 addresses 0x000 plus the offset.
- R5: In access mode, an offset of 0x60 or above addresses 0xF00 plus the offset, whatever the bank register holds.
- R6: In full mode (req_mode 2) the address is req_full_addr, and the bank register has no effect.
- R7: A write to a bank whose mask bit is 0 changes no stored byte in any bank. Bank 15 is always treated as present.
- R8: A read from a bank whose mask bit is 0 returns 0x00.
- R9: done pulses for exactly one cycle, in the cycle after each accepted request, including requests to missing banks. It stays low otherwise.
- R10: rd_data carries the addressed byte in the cycle after a read of a present bank. After a write, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 0 banked, 1 access window, 2 full address |
| req_write | input | 1 | 1 write, 0 read |
| req_offset | input | 8 | Low-order offset for banked and access modes |
| req_full_addr | input | 12 | Complete address for full mode |
| req_wdata | input | 8 | Write data |
| bank_load | input | 1 | Load the bank register from bank_load_val |
| bank_load_val | input | 8 | Immediate bank value; only bits 3:0 are kept |
| rd_data | output | 8 | Read data, valid with done |
| done | output | 1 | Completion strobe, one cycle after a request |
| bank_value | output | 8 | Bank register, upper bits zero |

## Verification
A bank load and a banked request can arrive in the same cycle. The bench raises bank_load to move from bank 1 to bank 2 and, in the same cycle, issues a banked write at offset 0x30. It then reads 0x130 and expects the new byte there, and reads 0x230 and expects that location's earlier contents to be unchanged. A write to a missing bank whose storage slot would fall on bank 15 is also checked: the bench reads back the bank 15 byte and expects it to be intact.

// File: rtl/bmau_pkg.sv
package bmau_pkg;

    typedef enum logic [1:0] {
        AMODE_BANKED = 2'd0,
        AMODE_ACCESS = 2'd1,
        AMODE_FULL   = 2'd2
    } amode_e;

    // Number of present banks strictly below bank index b.
    function automatic int unsigned slot_of(input logic [31:0] mask, input int unsigned b);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < b && mask[i]) n++;
        end
        return n;
    endfunction

    function automatic int unsigned present_count(input logic [31:0] mask, input int unsigned nb);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < nb && mask[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/bmau_addr_mux.sv
module bmau_addr_mux
    import bmau_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 8,
    parameter logic [OFF_W-1:0] ACCESS_SPLIT = 8'h60,
    localparam int BANK_W = ADDR_W - OFF_W
) (
    input  amode_e              mode,
    input  logic [BANK_W-1:0]   bank,
    input  logic [OFF_W-1:0]    offset,
    input  logic [ADDR_W-1:0]   full_addr,
    output logic [ADDR_W-1:0]   addr
);
    always_comb begin
        unique case (mode)
            AMODE_BANKED: addr = {bank, offset};
            AMODE_ACCESS: begin
                if (offset < ACCESS_SPLIT) addr = {{BANK_W{1'b0}}, offset};
                else                       addr = {{BANK_W{1'b1}}, offset};
            end
            default:      addr = full_addr;
        endcase
    end
endmodule

// File: rtl/bmau_bank_map.sv
module bmau_bank_map
    import bmau_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int SLOT_W = 3,
    localparam int NBANKS = 1 << BANK_W,
    parameter logic [NBANKS-1:0] PRESENT = 16'h800F
) (
    input  logic [BANK_W-1:0] bank,
    output logic              present,
    output logic [SLOT_W-1:0] slot
);
    logic [NBANKS-1:0] present_vec;
    logic [SLOT_W-1:0] slot_tab [NBANKS];

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        assign present_vec[g] = PRESENT[g];
        assign slot_tab[g]    = SLOT_W'(slot_of(32'(PRESENT), g));
    end

    assign present = present_vec[bank];
    assign slot    = slot_tab[bank];
endmodule

// File: rtl/bmau_store.sv
module bmau_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 11,
    parameter int DEPTH  = 1280
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata_q  <= mem[idx];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bmau_top.sv
module bmau_top
    import bmau_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter logic [(1<<(ADDR_W-OFF_W))-1:0] BANK_MASK = 16'h800F,
    parameter logic [OFF_W-1:0] ACCESS_SPLIT = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [ADDR_W-1:0] req_full_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bank_load,
    input  logic [DATA_W-1:0] bank_load_val,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [DATA_W-1:0] bank_value
);
    localparam int BANK_W  = ADDR_W - OFF_W;
    localparam int NBANKS  = 1 << BANK_W;
    localparam logic [NBANKS-1:0] EFF_MASK = BANK_MASK | (NBANKS'(1) << (NBANKS-1));
    localparam int PHYS    = present_count(32'(EFF_MASK), NBANKS);
    localparam int SLOT_W  = (PHYS > 1) ? $clog2(PHYS) : 1;
    localparam int IDX_W   = SLOT_W + OFF_W;
    localparam int DEPTH   = PHYS << OFF_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              done;
        logic              rd_ok;
    } state_t;

    state_t s_d, s_q;

    logic [ADDR_W-1:0] mem_addr;
    logic              bank_ok;
    logic [SLOT_W-1:0] slot;
    logic              ram_we, ram_re;
    logic [DATA_W-1:0] ram_q;
    logic [IDX_W-1:0]  ram_idx;

    bmau_addr_mux #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ACCESS_SPLIT(ACCESS_SPLIT)
    ) u_mux (
        .mode(amode_e'(req_mode)),
        .bank(s_q.bank),
        .offset(req_offset),
        .full_addr(req_full_addr),
        .addr(mem_addr)
    );

    bmau_bank_map #(
        .BANK_W(BANK_W), .SLOT_W(SLOT_W), .PRESENT(EFF_MASK)
    ) u_map (
        .bank(mem_addr[ADDR_W-1:OFF_W]),
        .present(bank_ok),
        .slot(slot)
    );

    assign ram_idx = {slot, mem_addr[OFF_W-1:0]};
    assign ram_we  = req_valid &&  req_write && bank_ok;
    assign ram_re  = req_valid && !req_write && bank_ok;

    bmau_store #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk),
        .we(ram_we),
        .re(ram_re),
        .idx(ram_idx),
        .wdata(req_wdata),
        .rdata(ram_q)
    );

    always_comb begin
        s_d = s_q;
        if (bank_load) s_d.bank = bank_load_val[BANK_W-1:0];
        s_d.done  = req_valid;
        s_d.rd_ok = ram_re;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done       = s_q.done;
    assign rd_data    = s_q.rd_ok ? ram_q : '0;
    assign bank_value = DATA_W'(s_q.bank);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> bank_value == DATA_W'($past(bank_load_val[BANK_W-1:0]))); // R3
    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_load |=> $stable(bank_value)); // R3
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R9
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done); // R9
    AST_MISSING_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !bank_ok |=> rd_data == '0); // R8
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rd_data == '0); // R10
    AST_ACCESS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_mode == 2'd1 && req_offset >= ACCESS_SPLIT
        |-> mem_addr[ADDR_W-1:OFF_W] == '1); // R5
    AST_FULL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_mode == 2'd2 |-> mem_addr == req_full_addr); // R6
endmodule

// File: tb/bmau_top_test.sv
module bmau_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offset = '0;
    logic [11:0] req_full_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        bank_load = 1'b0;
    logic [7:0]  bank_load_val = '0;
    logic [7:0]  rd_data;
    logic        done;
    logic [7:0]  bank_value;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmau_top #(.BANK_MASK(16'h800F)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_write(req_write), .req_offset(req_offset), .req_full_addr(req_full_addr),
        .req_wdata(req_wdata), .bank_load(bank_load), .bank_load_val(bank_load_val),
        .rd_data(rd_data), .done(done), .bank_value(bank_value)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input bit wr, input logic [7:0] off,
                         input logic [11:0] fa, input logic [7:0] wd,
                         input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bank_load = 1'b0;
        req_valid = 1'b1; req_mode = m; req_write = wr;
        req_offset = off; req_full_addr = fa; req_wdata = wd;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; bank_load = 1'b0;
    endtask

    task automatic load_bank(input logic [7:0] v, input logic [7:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b0; bank_load = 1'b1; bank_load_val = v;
        @(negedge clk);
        bank_load = 1'b0;
        check(bank_value == exp, tag, bank_value, exp);
    endtask

    // Monitor: every done pops one expected item; done without one is a failure.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(rd_data == it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check(bank_value == 8'h00, "R2 reset bank", bank_value, 0);
        check(done == 1'b0, "R9 reset done", done, 0);
        check(rd_data == 8'h00, "R10 reset rdata", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        load_bank(8'hA3, 8'h03, "R2 upper bits dropped");              // R2, R3
        drive(2'd0, 1, 8'h10, 12'h000, 8'h5A, 8'h00, "R10 write data zero");
        drive(2'd2, 0, 8'h00, 12'h310, 8'h00, 8'h5A, "R1 banked write at 0x310");
        drive(2'd2, 1, 8'h00, 12'h120, 8'h77, 8'h00, "R6 full write");
        drive(2'd2, 1, 8'h00, 12'h230, 8'hEE, 8'h00, "R6 full write 0x230");
        idle();
        load_bank(8'h01, 8'h01, "R3 load bank 1");
        drive(2'd0, 0, 8'h20, 12'h000, 8'h00, 8'h77, "R1 banked read 0x120");
        drive(2'd2, 0, 8'h00, 12'h310, 8'h00, 8'h5A, "R6 full read ignores bank");
        // access window, bank register is 1
        drive(2'd1, 1, 8'h05, 12'h000, 8'h11, 8'h00, "R4 access write low");
        drive(2'd1, 1, 8'h80, 12'h000, 8'h22, 8'h00, "R5 access write high");
        drive(2'd1, 1, 8'h5F, 12'h000, 8'h33, 8'h00, "R4 access write 0x5F");
        drive(2'd1, 1, 8'h60, 12'h000, 8'h44, 8'h00, "R5 access write 0x60");
        drive(2'd2, 0, 8'h00, 12'h005, 8'h00, 8'h11, "R4 read 0x005");
        drive(2'd2, 0, 8'h00, 12'hF80, 8'h00, 8'h22, "R5 read 0xF80");
        drive(2'd2, 0, 8'h00, 12'h05F, 8'h00, 8'h33, "R4 boundary 0x05F");
        drive(2'd2, 0, 8'h00, 12'hF60, 8'h00, 8'h44, "R5 boundary 0xF60");
        // missing banks: bank 4 would share the storage slot of bank 15
        drive(2'd2, 1, 8'h00, 12'h480, 8'h99, 8'h00, "R9 missing write completes");
        drive(2'd2, 0, 8'h00, 12'h480, 8'h00, 8'h00, "R8 missing read zero");
        drive(2'd2, 0, 8'h00, 12'hF80, 8'h00, 8'h22, "R7 bank 15 intact");
        idle();
        load_bank(8'h07, 8'h07, "R3 load bank 7");
        drive(2'd0, 1, 8'h60, 12'h000, 8'h66, 8'h00, "R9 banked missing write");
        drive(2'd0, 0, 8'h60, 12'h000, 8'h00, 8'h00, "R8 banked missing read");
        drive(2'd2, 0, 8'h00, 12'hF60, 8'h00, 8'h44, "R7 bank 15 intact 0xF60");
        idle();
        load_bank(8'h01, 8'h01, "R3 back to bank 1");
        // load and banked write in the same cycle: write uses old bank 1
        begin
            item_t it;
            @(negedge clk);
            bank_load = 1'b1; bank_load_val = 8'h02;
            req_valid = 1'b1; req_mode = 2'd0; req_write = 1'b1;
            req_offset = 8'h30; req_wdata = 8'h45;
            it.exp = 8'h00; it.tag = "R3 same-cycle write";
            exp_q.push_back(it);
        end
        drive(2'd2, 0, 8'h00, 12'h130, 8'h00, 8'h45, "R3 same-cycle used old bank");
        drive(2'd2, 0, 8'h00, 12'h230, 8'h00, 8'hEE, "R3 new bank untouched");
        idle();
        check(bank_value == 8'h02, "R3 load took effect", bank_value, 2);
        load_bank(8'hFF, 8'h0F, "R2 upper nibble zero");
        // back-to-back reads, one-cycle latency
        drive(2'd1, 0, 8'h05, 12'h000, 8'h00, 8'h11, "R10 back-to-back read 1");
        drive(2'd1, 0, 8'h80, 12'h000, 8'h00, 8'h22, "R10 back-to-back read 2");
        drive(2'd0, 0, 8'h80, 12'h000, 8'h00, 8'h22, "R1 banked read bank 15");
        idle();
        idle();
        idle();
        check(exp_q.size() == 0, "R9 all requests completed", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule